// File: doc/BRIEF.md
# Handshake Bus Master Sequencer

This block is the master side of an asynchronous, interlocked bus. A local client asks for one access at a time through a request/response port. The block then runs the matching bus cycle: a word or byte read, a word or byte write, or an indivisible read-modify-write. The cycle is a sequence of phases S0 to S7. Each phase lasts one clock of the block. The sequence stops in a wait phase until the addressed slave pulls its active-low acknowledge.

The acknowledge comes from another timing domain. It enters through a chain of two flops before the phase logic sees it. After each access the master waits until the acknowledge has gone high again before it accepts the next request. A read-modify-write holds the address strobe low across both halves, so no other master can come between the read and the write. The read half drives read/write high. The write half drives it low. Each half has its own data-strobe pulse.

Top module: `hsbus_master`

## Requirements
- R1: A read whose acknowledge comes back on the first clock after the data strobes fall keeps the address strobe low for exactly 5 clocks, so the whole access takes eight phases.
- R2: The address bus holds the requested word address on the clock where the address strobe falls, and it does not change while the strobe is low.
- R3: The address strobe falls only after the address has been stable for a clock. It rises while the address still holds the requested value.
- R4: In a read (req_op 0), the data strobes fall on the same clock as the address strobe, with read/write high. The response carries the bus data sampled near the end of the cycle, with the lanes that were not selected forced to zero. rsp_valid is a one-clock pulse.
- R5: In a write (req_op 1), read/write is low and the data-out enable is high before the data strobes fall. The strobes fall exactly two clocks after the address strobe.
- R6: Each extra clock by which the slave delays its acknowledge lengthens the address-strobe-low time by exactly one clock.
- R7: The acknowledge passes through a two-flop synchronizer. A write whose acknowledge comes back on the first clock after the strobes fall keeps the address strobe low for exactly 7 clocks.
- R8: In a read-modify-write (req_op 2), the address strobe stays low through both halves and rises once. The data strobes fall twice: first with read/write high, then with it low. The response returns the old data and the slave ends up holding the new data.
- R9: req_lanes bit 1 selects the upper data strobe and bit 0 the lower. Only the strobes of the selected lanes fall. A value of 0 is treated as both lanes.
- R10: While the synchronized acknowledge is still low, req_ready stays low and no new cycle starts. The pending request runs once the acknowledge has gone high.
- R11: After reset, the address strobe, both data strobes and read/write are high, the data-out enable is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one phase per clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Write data (write and the write half of read-modify-write) |
| req_lanes | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| req_ready | output | 1 | Request is accepted on a clock where both valid and ready are high |
| rsp_valid | output | 1 | One-clock pulse when the access ends |
| rsp_rdata | output | DATA_W | Read data, masked to the selected lanes |
| bus_addr | output | ADDR_W | Address bus |
| bus_dout | output | DATA_W | Write data bus |
| bus_doe | output | 1 | Enable for the write data bus |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rw | output | 1 | High for read, low for write |
| bus_din | input | DATA_W | Read data bus from the slave |
| bus_ack_n | input | 1 | Slave acknowledge, active low, asynchronous |

## Verification
The hardest overlap is the synchronized acknowledge arriving on the very clock the phase logic enters its wait phase. With a slave that answers at once, a read has no slack. Here the synchronizer output rises on the same edge that moves the sequencer into S4. The bench provokes this with a zero-delay slave and judges it by the exact address-strobe-low count of 5: one clock more would mean the wait phase missed it. Slaves delayed by several clocks must add exactly that delay. A second overlap is the end of one access against a new request while the acknowledge is still low. The bench tests it by holding the acknowledge low while a request is pending.

// File: rtl/hsbus_pkg.sv
package hsbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_S3,
        ST_S4,
        ST_S5,
        ST_S6,
        ST_S7
    } hs_state_e;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_RMW   = 2'd2;

endpackage

// File: rtl/hsbus_ack_sync.sv
module hsbus_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_async_n,
    output logic ack_seen
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = ~ack_async_n;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign ack_seen = chain_q[STAGES-1];
endmodule

// File: rtl/hsbus_lane_dec.sv
module hsbus_lane_dec #(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        lanes_in,
    output logic [1:0]        lanes_eff,
    output logic [DATA_W-1:0] lane_mask
);
    localparam int HALF_W = DATA_W / 2;

    assign lanes_eff = (lanes_in == 2'b00) ? 2'b11 : lanes_in;
    assign lane_mask = {{HALF_W{lanes_eff[1]}}, {HALF_W{lanes_eff[0]}}};
endmodule

// File: rtl/hsbus_seq.sv
module hsbus_seq
    import hsbus_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        lanes_eff,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic              ack_seen,
    input  logic [DATA_W-1:0] bus_din,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw
);
    typedef struct packed {
        hs_state_e         st;
        logic              second;
        logic [1:0]        op;
        logic [1:0]        lanes;
        logic [DATA_W-1:0] mask;
        logic [ADDR_W-1:0] tgt;
        logic [DATA_W-1:0] wdata;
        logic [ADDR_W-1:0] addr;
        logic              as_n;
        logic              uds_n;
        logic              lds_n;
        logic              rw;
        logic              doe;
        logic [DATA_W-1:0] rdata;
        logic              rsp;
    } seq_t;

    seq_t seq_d, seq_q;
    logic wr_phase;
    logic locked_first;

    assign wr_phase     = (seq_q.op == OP_WRITE) || ((seq_q.op == OP_RMW) && seq_q.second);
    assign locked_first = (seq_q.op == OP_RMW) && !seq_q.second;

    always_comb begin
        seq_d     = seq_q;
        seq_d.rsp = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid && !ack_seen) begin
                    seq_d.st     = ST_S0;
                    seq_d.op     = req_op;
                    seq_d.lanes  = lanes_eff;
                    seq_d.mask   = lane_mask;
                    seq_d.tgt    = req_addr;
                    seq_d.wdata  = req_wdata;
                    seq_d.second = 1'b0;
                end
            end
            ST_S0: begin
                seq_d.st   = ST_S1;
                seq_d.addr = seq_q.tgt;
            end
            ST_S1: begin
                seq_d.st   = ST_S2;
                seq_d.as_n = 1'b0;
                if (wr_phase) begin
                    seq_d.rw  = 1'b0;
                    seq_d.doe = 1'b1;
                end else begin
                    seq_d.uds_n = ~seq_q.lanes[1];
                    seq_d.lds_n = ~seq_q.lanes[0];
                end
            end
            ST_S2: begin
                seq_d.st = ST_S3;
            end
            ST_S3: begin
                if (!wr_phase) begin
                    seq_d.st = ST_S4;
                end else if (!ack_seen) begin
                    seq_d.st    = ST_S4;
                    seq_d.uds_n = ~seq_q.lanes[1];
                    seq_d.lds_n = ~seq_q.lanes[0];
                end
            end
            ST_S4: begin
                if (ack_seen) begin
                    seq_d.st = ST_S5;
                end
            end
            ST_S5: begin
                seq_d.st = ST_S6;
                if (!wr_phase) begin
                    seq_d.rdata = bus_din & seq_q.mask;
                end
            end
            ST_S6: begin
                seq_d.st    = ST_S7;
                seq_d.uds_n = 1'b1;
                seq_d.lds_n = 1'b1;
                if (!locked_first) begin
                    seq_d.as_n = 1'b1;
                end
            end
            ST_S7: begin
                if (locked_first) begin
                    seq_d.second = 1'b1;
                    seq_d.st     = ST_S0;
                end else begin
                    seq_d.st  = ST_IDLE;
                    seq_d.doe = 1'b0;
                    seq_d.rw  = 1'b1;
                    seq_d.rsp = 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.st     <= ST_IDLE;
            seq_q.as_n   <= 1'b1;
            seq_q.uds_n  <= 1'b1;
            seq_q.lds_n  <= 1'b1;
            seq_q.rw     <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE) && !ack_seen;
    assign rsp_valid = seq_q.rsp;
    assign rsp_rdata = seq_q.rdata;
    assign bus_addr  = seq_q.addr;
    assign bus_dout  = seq_q.wdata;
    assign bus_doe   = seq_q.doe;
    assign bus_as_n  = seq_q.as_n;
    assign bus_uds_n = seq_q.uds_n;
    assign bus_lds_n = seq_q.lds_n;
    assign bus_rw    = seq_q.rw;
endmodule

// File: rtl/hsbus_master.sv
module hsbus_master #(
    parameter int ADDR_W      = 23,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_lanes,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic              bus_rw,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ack_n
);
    logic              ack_seen;
    logic [1:0]        lanes_eff;
    logic [DATA_W-1:0] lane_mask;

    hsbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_async_n (bus_ack_n),
        .ack_seen    (ack_seen)
    );

    hsbus_lane_dec #(.DATA_W(DATA_W)) u_lanes (
        .lanes_in  (req_lanes),
        .lanes_eff (lanes_eff),
        .lane_mask (lane_mask)
    );

    hsbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lanes_eff (lanes_eff),
        .lane_mask (lane_mask),
        .ack_seen  (ack_seen),
        .bus_din   (bus_din),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_as_n  (bus_as_n),
        .bus_uds_n (bus_uds_n),
        .bus_lds_n (bus_lds_n),
        .bus_rw    (bus_rw)
    );
endmodule

// File: rtl/hsbus_master_chk.sv
module hsbus_master_chk #(
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_doe,
    input logic              bus_as_n,
    input logic              bus_uds_n,
    input logic              bus_lds_n,
    input logic              bus_rw
);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> (bus_addr == $past(bus_addr)));

    // R3
    as_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as_n) |-> $stable(bus_addr));

    // R4
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    // R5
    wr_data_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!bus_uds_n || !bus_lds_n) && !bus_rw) |-> bus_doe);

    // R8
    rw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bus_rw) |-> (bus_uds_n && bus_lds_n));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind hsbus_master hsbus_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bus_doe   (bus_doe),
    .bus_as_n  (bus_as_n),
    .bus_uds_n (bus_uds_n),
    .bus_lds_n (bus_lds_n),
    .bus_rw    (bus_rw)
);

// File: tb/hsbus_master_test.sv
`timescale 1ns/1ps
module hsbus_master_test;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam int NV = 11;

    // fields: [40:39] op, [38:35] addr, [34:33] lanes, [32:17] wdata, [16:1] expected, [0] check data
    localparam logic [40:0] VEC [0:NV-1] = '{
        {2'd0, 4'd3, 2'b11, 16'h0000, 16'hC333, 1'b1},
        {2'd0, 4'd5, 2'b10, 16'h0000, 16'hC500, 1'b1},
        {2'd0, 4'd5, 2'b01, 16'h0000, 16'h0035, 1'b1},
        {2'd1, 4'd7, 2'b11, 16'h1234, 16'h0000, 1'b0},
        {2'd0, 4'd7, 2'b11, 16'h0000, 16'h1234, 1'b1},
        {2'd1, 4'd2, 2'b10, 16'hABCD, 16'h0000, 1'b0},
        {2'd0, 4'd2, 2'b11, 16'h0000, 16'hAB32, 1'b1},
        {2'd1, 4'd2, 2'b01, 16'h99EF, 16'h0000, 1'b0},
        {2'd0, 4'd2, 2'b11, 16'h0000, 16'hABEF, 1'b1},
        {2'd2, 4'd9, 2'b11, 16'h0F0F, 16'hC939, 1'b1},
        {2'd0, 4'd9, 2'b11, 16'h0000, 16'h0F0F, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    req_lanes = 2'b11;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, bus_din;
    logic          bus_doe, bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_ack_n;

    logic [DW-1:0] mem [0:15];
    logic          slv_ack_n = 1'b1;
    logic          stuck = 1'b0;
    int            slv_dly = 0;
    int            slv_cnt = 0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int samp = 0, as_low = 0, as_rises = 0, ds_falls = 0, as_fall_at = 0, ds_fall_at = 0;
    logic rw_first, rw_last, uds_seen, lds_seen, bad_doe, addr_moved;
    logic [AW-1:0] addr_at_fall, addr_at_rise;
    logic prev_as = 1'b1, prev_ds = 1'b0;
    logic [DW-1:0] got;

    always #5 clk = ~clk;

    hsbus_master #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
        .bus_rw(bus_rw), .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    assign bus_din   = mem[bus_addr[3:0]];
    assign bus_ack_n = slv_ack_n & ~stuck;

    // slave model: acknowledges slv_dly negedges after a data strobe falls
    always @(negedge clk) begin
        if (bus_uds_n && bus_lds_n) begin
            slv_ack_n <= 1'b1;
            slv_cnt   <= 0;
        end else if (slv_ack_n && slv_cnt >= slv_dly) begin
            slv_ack_n <= 1'b0;
            if (!bus_rw && bus_doe) begin
                if (!bus_uds_n) mem[bus_addr[3:0]][15:8] <= bus_dout[15:8];
                if (!bus_lds_n) mem[bus_addr[3:0]][7:0]  <= bus_dout[7:0];
            end
        end else if (slv_ack_n) begin
            slv_cnt <= slv_cnt + 1;
        end
    end

    // bus monitor
    always @(negedge clk) begin
        logic ds_any;
        ds_any = !bus_uds_n || !bus_lds_n;
        samp = samp + 1;
        if (!bus_as_n) as_low = as_low + 1;
        if (prev_as && !bus_as_n) begin
            as_fall_at   = samp;
            addr_at_fall = bus_addr;
        end
        if (!prev_as && bus_as_n) begin
            as_rises     = as_rises + 1;
            addr_at_rise = bus_addr;
        end
        if (!prev_as && !bus_as_n && bus_addr != addr_at_fall) addr_moved = 1'b1;
        if (ds_any && !prev_ds) begin
            ds_falls = ds_falls + 1;
            if (ds_falls == 1) begin
                ds_fall_at = samp;
                rw_first   = bus_rw;
            end
            rw_last = bus_rw;
        end
        if (!bus_uds_n) uds_seen = 1'b1;
        if (!bus_lds_n) lds_seen = 1'b1;
        if (ds_any && !bus_rw && !bus_doe) bad_doe = 1'b1;
        prev_as = bus_as_n;
        prev_ds = ds_any;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        as_low = 0; as_rises = 0; ds_falls = 0; as_fall_at = 0; ds_fall_at = 0;
        rw_first = 1'bx; rw_last = 1'bx;
        uds_seen = 1'b0; lds_seen = 1'b0; bad_doe = 1'b0; addr_moved = 1'b0;
    endtask

    task automatic wait_rsp();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got = rsp_rdata;
        @(negedge clk);
    endtask

    task automatic run_txn(input logic [1:0] op, input logic [3:0] a, input logic [1:0] ln, input logic [15:0] wd);
        @(negedge clk);
        #1;
        clear_mon();
        req_op    = op;
        req_addr  = {{(AW-4){1'b0}}, a};
        req_lanes = ln;
        req_wdata = wd;
        req_valid = 1'b1;
        wait_rsp();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = {4'hC, i[3:0], 4'h3, i[3:0]};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bus_as_n == 1'b1 && bus_uds_n && bus_lds_n, "R11 strobes high in reset", {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
        chk(bus_rw == 1'b1 && bus_doe == 1'b0, "R11 rw high doe low", {bus_rw, bus_doe}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            logic [1:0]  ln;
            logic [3:0]  a;
            v  = VEC[i];
            ln = v[34:33];
            a  = v[38:35];
            run_txn(v[40:39], a, ln, v[32:17]);
            if (v[0]) chk(got == v[16:1], "R4 R8 response data", got, v[16:1]);
            chk({uds_seen, lds_seen} == ln, "R9 strobe lanes", {uds_seen, lds_seen}, ln);
            chk(addr_at_fall == {{(AW-4){1'b0}}, a} && !addr_moved, "R2 address at strobe", addr_at_fall, a);
            chk(addr_at_rise == {{(AW-4){1'b0}}, a}, "R3 address held at strobe rise", addr_at_rise, a);
            if (v[40:39] == 2'd0) begin
                chk(ds_fall_at == as_fall_at && rw_first == 1'b1, "R4 read strobe timing", ds_fall_at - as_fall_at, 0);
                chk(as_low == 5, "R1 read strobe length", as_low, 5);
            end else if (v[40:39] == 2'd1) begin
                chk(ds_fall_at - as_fall_at == 2 && rw_first == 1'b0 && !bad_doe, "R5 write strobe order", ds_fall_at - as_fall_at, 2);
                chk(as_low == 7, "R7 write strobe length", as_low, 7);
            end else begin
                chk(as_rises == 1 && ds_falls == 2, "R8 locked strobes", {as_rises[7:0], ds_falls[7:0]}, 16'h0102);
                chk(rw_first == 1'b1 && rw_last == 1'b0 && !bad_doe, "R8 rw order", {rw_first, rw_last}, 2'b10);
            end
        end

        // R6: delayed acknowledge adds exactly its delay
        slv_dly = 3;
        run_txn(2'd0, 4'd3, 2'b11, 16'h0);
        chk(as_low == 8, "R6 read with 3 extra clocks", as_low, 8);
        chk(got == 16'hC333, "R6 read data with wait", got, 16'hC333);
        slv_dly = 2;
        run_txn(2'd1, 4'd4, 2'b11, 16'h5AA5);
        chk(as_low == 9, "R6 write with 2 extra clocks", as_low, 9);
        slv_dly = 0;
        run_txn(2'd0, 4'd4, 2'b00, 16'h0);
        chk(got == 16'h5AA5, "R6 written data read back", got, 16'h5AA5);
        chk(uds_seen && lds_seen, "R9 lanes zero means both", {uds_seen, lds_seen}, 2'b11);

        // R10: stuck acknowledge blocks the next start
        @(negedge clk);
        #1;
        clear_mon();
        stuck = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low while ack low", req_ready, 0);
        req_op = 2'd0; req_addr = {{(AW-4){1'b0}}, 4'd3}; req_lanes = 2'b11; req_valid = 1'b1;
        begin
            logic started;
            started = 1'b0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (!bus_as_n) started = 1'b1;
            end
            chk(!started, "R10 no cycle while ack low", started, 0);
        end
        stuck = 1'b0;
        wait_rsp();
        chk(got == 16'hC333, "R10 pending read after release", got, 16'hC333);

        finish_run();
    end
endmodule